// File: doc/BRIEF.md
# Countdown Timer with Sticky Interrupt

This block is a host-programmed down-counter that flags an interrupt when its count runs out. A single 32-bit control word carries a 20-bit start value, a count-enable bit, an interrupt-enable bit and an acknowledge bit. Writing the word with count-enable set loads the start value. The counter then steps down by one on every cycle where the `tick` input is high, so `tick` is the output of a prescaler outside the block. The count stops at zero and is not reloaded.

The step from one to zero sets a sticky flag. The flag is reported in bit 5 of a 16-bit status word. It drives `irq_o` while interrupt-enable is set. A control write with the acknowledge bit set is treated as an acknowledge-only write. It clears the flag and updates interrupt-enable, and it leaves the running count untouched, so a countdown continues through its own acknowledge.

The core is a three-state machine:
- `ST_IDLE`: counting is off.
- `ST_RUN`: counting, with the count nonzero.
- `ST_EXPIRED`: counting is enabled and the count is zero.

Its transitions are:
- `start` (any state to `ST_RUN`): a load with enable set and a nonzero value.
- `load_zero` (any state to `ST_EXPIRED`): a load with enable set and a value of zero.
- `stop` (any state to `ST_IDLE`): a load with enable clear.
- `expire` (`ST_RUN` to `ST_EXPIRED`): a tick while the count is one.

Top module: `tick_countdown_irq`

## Requirements
- R1: After reset the control readback is 0x00000000, the status readback is 0x00000000 and `irq_o` is low.
- R2: Address 0 is the control word. A write to it without bit 26 stores bit 25 as interrupt-enable. If bit 24 is set, the write also sets count-enable and loads bits 19:0 into the count. Reading address 0 returns the count in bits 19:0, count-enable in bit 24 and interrupt-enable in bit 25, with all other bits read as 0.
- R3: While counting is enabled and the count is nonzero, each cycle with `tick` high lowers the count by exactly one. A cycle with `tick` low leaves the count unchanged.
- R4: A control write with bit 24 clear and bit 26 clear stops counting. The count keeps its value, the written bits 19:0 are ignored, and later ticks do not change the count.
- R5: The tick that takes the count from 1 to 0 sets the interrupt flag. The count then holds at 0 on further ticks and is not reloaded.
- R6: Loading a value of 0 with bit 24 set leaves the interrupt flag clear, including on ticks that follow.
- R7: Address 1 is the 16-bit status word. Bit 5 reads the interrupt flag and all other bits read 0. The flag stays set until it is acknowledged, whatever the ticks do.
- R8: A control write with bit 26 set clears the flag and stores bit 25 as interrupt-enable. It leaves the count and count-enable unchanged, and that cycle's tick still counts. If that tick takes the count to zero, the flag ends up set.
- R9: `irq_o` is high exactly when the flag is set and interrupt-enable is 1. Setting interrupt-enable while a flag is pending raises `irq_o`.
- R10: A loading control write in the same cycle as a tick takes precedence, and the count equals the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 status) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational from the address |
| tick | input | 1 | Count step from the prescaler |
| irq_o | output | 1 | Timer interrupt request |

## Verification
The bench builds the block with its default parameters: a 20-bit count, a 32-bit word, and the enable, interrupt-enable and acknowledge bits at 24, 25 and 26. With these, loading the full-scale value 0xFFFFF and stepping it down shows that the top count bits are not clipped. Ignored bits between the fields show that they are discarded on readback. Short counts of one to ten ticks reach the zero step, the acknowledge-versus-expire collision and the write-versus-tick collision within a few dozen cycles.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    // Timer sequencing states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_EXPIRED = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs #(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 20,
    parameter int STAT_W    = 16,
    parameter int EN_BIT    = 24,
    parameter int IE_BIT    = 25,
    parameter int ACK_BIT   = 26,
    parameter int FLAG_BIT  = 5,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              cnt_en,
    input  logic              flag,
    output logic              load,
    output logic              load_en,
    output logic [CNT_W-1:0]  load_val,
    output logic              ack,
    output logic              ie,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    logic ctrl_wr;
    logic ie_q;
    logic [STAT_W-1:0] stat_word;
    logic wr_unused;

    assign ctrl_wr  = wr_en && (wr_addr == CTRL_A);
    assign ack      = ctrl_wr && wr_data[ACK_BIT];
    assign load     = ctrl_wr && !wr_data[ACK_BIT];
    assign load_en  = wr_data[EN_BIT];
    assign load_val = wr_data[CNT_W-1:0];
    assign ie       = ie_q;
    assign wr_unused = ^wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
        end else if (ctrl_wr) begin
            ie_q <= wr_data[IE_BIT];
        end
    end

    always_comb begin
        stat_word           = '0;
        stat_word[FLAG_BIT] = flag;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_A) begin
            rd_data[CNT_W-1:0] = cnt;
            rd_data[EN_BIT]    = cnt_en;
            rd_data[IE_BIT]    = ie_q;
        end else if (rd_addr == STAT_A) begin
            rd_data[STAT_W-1:0] = stat_word;
        end
    end

    // R2
    ie_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ie_q == $past(wr_data[IE_BIT])));

    // R2
    ie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ie_q));
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
    import cdt_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_en,
    output logic             zero_evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic last_step;

    assign last_step = (state_q == ST_RUN) && tick && !load && (cnt_q == ONE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (load) begin
            if (!load_en) begin
                state_d = ST_IDLE;               // stop
            end else if (load_val != '0) begin
                state_d = ST_RUN;                // start
                cnt_d   = load_val;
            end else begin
                state_d = ST_EXPIRED;            // load_zero
                cnt_d   = '0;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_RUN: begin
                    if (tick) begin
                        cnt_d = cnt_q - ONE;
                        if (cnt_q == ONE) begin
                            state_d = ST_EXPIRED; // expire
                        end
                    end
                end
                ST_EXPIRED: begin
                    state_d = ST_EXPIRED;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        cnt      = cnt_q;
        cnt_en   = (state_q != ST_IDLE);
        zero_evt = last_step;
    end

    // R3
    dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick && !load) |=> (cnt_q == $past(cnt_q) - ONE));

    // R3
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q));

    // R4
    stopped_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !load) |=> $stable(cnt_q));

    // R5
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXPIRED && !load) |=> (cnt_q == '0));

    // R3
    run_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q != '0));
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic zero_evt,
    input  logic ack,
    input  logic ie,
    output logic flag,
    output logic irq
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (zero_evt) begin
            flag_q <= 1'b1;
        end else if (ack) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
    assign irq  = flag_q && ie;

    // R5
    set_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> flag_q);

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !ack) |=> flag_q);

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !zero_evt) |=> !flag_q);

    // R7
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !zero_evt) |=> !flag_q);
endmodule

// File: rtl/tick_countdown_irq.sv
module tick_countdown_irq #(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 20,
    parameter int STAT_W    = 16,
    parameter int EN_BIT    = 24,
    parameter int IE_BIT    = 25,
    parameter int ACK_BIT   = 26,
    parameter int FLAG_BIT  = 5,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick,
    output logic              irq_o
);
    logic             load, load_en, ack, ie;
    logic [CNT_W-1:0] load_val, cnt;
    logic             cnt_en, zero_evt, flag;

    cdt_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .STAT_W(STAT_W),
        .EN_BIT(EN_BIT), .IE_BIT(IE_BIT), .ACK_BIT(ACK_BIT),
        .FLAG_BIT(FLAG_BIT), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .cnt(cnt), .cnt_en(cnt_en),
        .flag(flag), .load(load), .load_en(load_en), .load_val(load_val),
        .ack(ack), .ie(ie), .rd_data(rd_data)
    );

    cdt_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk(clk), .rst_n(rst_n), .load(load), .load_en(load_en),
        .load_val(load_val), .tick(tick), .cnt(cnt), .cnt_en(cnt_en),
        .zero_evt(zero_evt)
    );

    cdt_irq u_irq (
        .clk(clk), .rst_n(rst_n), .zero_evt(zero_evt), .ack(ack),
        .ie(ie), .flag(flag), .irq(irq_o)
    );

    // R6
    no_flag_on_zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_en && load_val == '0 && !flag) |=> !flag);

    // R9
    irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ie);
endmodule

// File: tb/test_tick_countdown_irq.sv
`timescale 1ns/1ps
module test_tick_countdown_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        tick = 1'b0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tick_countdown_irq i_tick_countdown_irq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick(tick), .irq_o(irq_o)
    );

    task automatic cyc(input logic t);
        tick = t;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic t);
        wr_en = 1'b1; wr_addr = a; wr_data = d; tick = t;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1);
    endtask

    task automatic chk_rd(input logic [1:0] a, input logic [31:0] exp, input string req);
        rd_addr = a;
        #0.5;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s addr %0d: actual 0x%08h expected 0x%08h", req, a, rd_data, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string req);
        #0.5;
        checks++;
        if (irq_o !== exp) begin
            errors++;
            $display("FAIL %s irq_o: actual %b expected %b", req, irq_o, exp);
        end
    endtask

    task automatic t_reset;
        chk_rd(2'd0, 32'h0, "R1");
        chk_rd(2'd1, 32'h0, "R1");
        chk_irq(1'b0, "R1");
    endtask

    task automatic t_load;
        wr(2'd0, 32'h0100_0005, 1'b0);
        chk_rd(2'd0, 32'h0100_0005, "R2");
        wr(2'd0, 32'hF9F1_2345, 1'b0);
        chk_rd(2'd0, 32'h0101_2345, "R2");
        wr(2'd0, 32'h010F_FFFF, 1'b0);
        ticks(2);
        chk_rd(2'd0, 32'h010F_FFFD, "R2 R3 full scale");
    endtask

    task automatic t_count;
        wr(2'd0, 32'h0100_000A, 1'b0);
        ticks(3);
        chk_rd(2'd0, 32'h0100_0007, "R3");
        cyc(1'b0); cyc(1'b0);
        chk_rd(2'd0, 32'h0100_0007, "R3 no tick");
        cyc(1'b1); cyc(1'b0); cyc(1'b1);
        chk_rd(2'd0, 32'h0100_0005, "R3 sparse ticks");
    endtask

    task automatic t_stop;
        wr(2'd0, 32'h0000_0055, 1'b0);
        chk_rd(2'd0, 32'h0000_0005, "R4");
        ticks(4);
        chk_rd(2'd0, 32'h0000_0005, "R4 ticks ignored");
        chk_rd(2'd1, 32'h0, "R4 no flag");
    endtask

    task automatic t_expire;
        wr(2'd0, 32'h0300_0003, 1'b0);
        ticks(2);
        chk_rd(2'd1, 32'h0, "R5 not yet");
        chk_irq(1'b0, "R9 not yet");
        ticks(1);
        chk_rd(2'd0, 32'h0300_0000, "R5 zero");
        chk_rd(2'd1, 32'h0000_0020, "R5 R7 flag");
        chk_irq(1'b1, "R9");
        ticks(3);
        chk_rd(2'd0, 32'h0300_0000, "R5 no reload");
        chk_rd(2'd1, 32'h0000_0020, "R7 sticky");
    endtask

    task automatic t_ack;
        wr(2'd0, 32'h0600_0000, 1'b0);
        chk_rd(2'd1, 32'h0, "R8 cleared");
        chk_irq(1'b0, "R8 irq low");
        chk_rd(2'd0, 32'h0300_0000, "R8 count and enable kept");
    endtask

    task automatic t_zero_load;
        wr(2'd0, 32'h0300_0000, 1'b0);
        chk_rd(2'd0, 32'h0300_0000, "R6 loaded zero");
        ticks(3);
        chk_rd(2'd1, 32'h0, "R6 no flag");
        chk_irq(1'b0, "R6 irq low");
    endtask

    task automatic t_collide;
        wr(2'd0, 32'h0100_0001, 1'b0);
        ticks(1);
        chk_rd(2'd1, 32'h0000_0020, "R8 setup flag");
        wr(2'd0, 32'h0100_0002, 1'b0);
        ticks(1);
        chk_rd(2'd0, 32'h0100_0001, "R8 setup count");
        wr(2'd0, 32'h0400_0000, 1'b1);
        chk_rd(2'd1, 32'h0000_0020, "R8 zero wins over ack");
        chk_rd(2'd0, 32'h0100_0000, "R8 tick counted during ack");
        chk_irq(1'b0, "R9 ie clear");
        wr(2'd0, 32'h0200_0000, 1'b0);
        chk_irq(1'b1, "R9 late ie");
        chk_rd(2'd0, 32'h0200_0000, "R9 readback");
        wr(2'd0, 32'h0400_0000, 1'b0);
        chk_rd(2'd1, 32'h0, "R8 final ack");
        chk_irq(1'b0, "R9 after ack");
    endtask

    task automatic t_wr_vs_tick;
        wr(2'd0, 32'h0100_0009, 1'b1);
        chk_rd(2'd0, 32'h0100_0009, "R10");
        ticks(1);
        chk_rd(2'd0, 32'h0100_0008, "R10 then counts");
    endtask

    task automatic t_stat_write;
        wr(2'd1, 32'hFFFF_FFFF, 1'b0);
        chk_rd(2'd1, 32'h0, "R7 status write ignored");
        chk_rd(2'd0, 32'h0100_0008, "R7 control untouched");
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_load;
        t_count;
        t_stop;
        t_expire;
        t_ack;
        t_zero_load;
        t_collide;
        t_wr_vs_tick;
        t_stat_write;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule